// File: doc/BRIEF.md
# Threshold-Flagged Packet Receive FIFO

This block is a single-clock receive buffer for packet streams. Each stored word carries a data field and two framing markers, start-of-packet and end-of-packet. The writer presents words with a valid strobe. The reader pulls words with a read enable and gets each word back one cycle later, qualified by a read-valid pulse.

Three status flags steer the consumer and the upstream sender:

- **Data-available** tells the reader that the fill level has passed a programmable low mark, so a burst can be fetched.
- **Packet-available** tells the reader that at least one whole packet, including its final word, is held. This lets the consumer run in store-and-forward fashion.
- **Pause request** rises when the fill level passes a programmable high mark. The space above that mark is headroom for words already in flight. The request stays up until the level has fallen back to the low mark.

The reader does not need to wait on any flag. It may keep read enable high at all times. A read of an empty buffer produces nothing and disturbs nothing. A write into a full buffer is discarded and recorded in a sticky error flag.

Top module: `pkt_rx_fifo`

## Requirements
- R1: Accepted words leave in write order, each with the start-of-packet and end-of-packet markers it was written with.
- R2: A read enable in a cycle where the buffer holds at least one word is accepted. In the following cycle rd_valid is 1 and rd_data, rd_sop and rd_eop show that word.
- R3: A read enable while the buffer is empty is ignored. rd_valid is 0 in the next cycle, and the fill level and pointers stay unchanged, so the next written word is the next word read.
- R4: A write while the fill level equals DEPTH is discarded, even when a read is accepted in the same cycle. It sets overflow, which then stays at 1 until reset.
- R5: A cycle with both an accepted read and an accepted write leaves the fill level unchanged.
- R6: data_avail is 1 exactly when the fill level is strictly greater than cfg_lo_thresh.
- R7: pkt_avail is 1 exactly when at least one stored word has its end-of-packet marker set. This holds also when one such word is written and another is read in the same cycle.
- R8: pause_req goes to 1 in the cycle after the fill level is updated to a value strictly greater than cfg_hi_thresh.
- R9: pause_req goes to 0 once the updated fill level is less than or equal to cfg_lo_thresh. Between the two thresholds it keeps its previous value.
- R10: While rst_n is 0 (asynchronous, active low), the buffer is emptied and rd_valid, rd_data, rd_sop, rd_eop, data_avail, pkt_avail, pause_req and overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lo_thresh | input | CNT_W | Low fill mark for data_avail and pause release |
| cfg_hi_thresh | input | CNT_W | High fill mark for the pause request |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| wr_sop | input | 1 | Start-of-packet marker of the written word |
| wr_eop | input | 1 | End-of-packet marker of the written word |
| rd_en | input | 1 | Read request, may be held high |
| rd_valid | output | 1 | Read word is valid this cycle |
| rd_data | output | DATA_W | Read data |
| rd_sop | output | 1 | Start-of-packet marker of the read word |
| rd_eop | output | 1 | End-of-packet marker of the read word |
| data_avail | output | 1 | Fill level above the low mark |
| pkt_avail | output | 1 | At least one complete packet stored |
| pause_req | output | 1 | Flow-control pause request |
| overflow | output | 1 | Sticky flag for a discarded write |

## Verification
Some events can land in the same cycle, and each such overlap is forced on purpose:

- **End-of-packet counting.** An end-of-packet word can be written while another end-of-packet word is read. The packet counter must then net to zero change. The bench forces this by holding one single-word packet and writing a second while reading the first. It then checks that pkt_avail never drops.
- **Full buffer.** A read and a write can coincide on a full buffer. The write must be discarded while the read still goes ahead.

Outside the directed cases, a long random phase mixes both overlaps with threshold changes. A behavioural queue model judges every output on every cycle.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;

   typedef enum logic {
      PAUSE_OFF = 1'b0,
      PAUSE_ON  = 1'b1
   } pause_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pkt_rx_fifo_store.sv
module pkt_rx_fifo_store
   import pkt_rx_fifo_pkg::*;
#(
   parameter int WORD_W = 34,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              rd_en,
   output logic              wr_acc,
   output logic              rd_acc,
   output logic              head_eop,
   output logic              full,
   output logic [WORD_W-1:0] rd_word,
   output logic              rd_valid,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  count_nxt
);

   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("pkt_rx_fifo_store: DEPTH must be a power of two >= 2");
   end
   if (WORD_W < 3) begin : g_bad_width
      $error("pkt_rx_fifo_store: WORD_W too small");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] wptr, rptr;
   logic              empty;

   assign empty    = (count == '0);
   assign full     = (count == FULL_LVL);
   assign wr_acc   = wr_valid & ~full;
   assign rd_acc   = rd_en & ~empty;
   assign head_eop = mem[rptr][WORD_W-2];
   assign count_nxt = count + CNT_W'(wr_acc) - CNT_W'(rd_acc);

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_acc && (wptr == ADDR_W'(i))) begin
            mem[i] <= wr_word;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr     <= '0;
         rptr     <= '0;
         count    <= '0;
         rd_word  <= '0;
         rd_valid <= 1'b0;
      end else begin
         count    <= count_nxt;
         rd_valid <= rd_acc;
         if (wr_acc) wptr <= wptr + 1'b1;
         if (rd_acc) begin
            rptr    <= rptr + 1'b1;
            rd_word <= mem[rptr];
         end
      end
   end

   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && count == '0) |=> !rd_valid);
   assert_empty_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_valid && count == '0) |=> (count == '0));
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_LVL);
   assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !rd_en && count == FULL_LVL) |=> (count == FULL_LVL));
   assert_rw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && rd_en && count != '0 && count != FULL_LVL) |=> $stable(count));
   assert_rd_valid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en));

endmodule

// File: rtl/pkt_rx_fifo_eopcnt.sv
module pkt_rx_fifo_eopcnt #(
   parameter int CNT_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic pkt_avail
);

   logic [CNT_W-1:0] eop_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eop_cnt <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   eop_cnt <= eop_cnt + 1'b1;
            2'b01:   eop_cnt <= eop_cnt - 1'b1;
            default: eop_cnt <= eop_cnt;
         endcase
      end
   end

   assign pkt_avail = (eop_cnt != '0);

   assert_eop_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |-> pkt_avail);
   assert_eop_pair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(eop_cnt));

endmodule

// File: rtl/pkt_rx_fifo_flags.sv
module pkt_rx_fifo_flags
   import pkt_rx_fifo_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] count_nxt,
   input  logic [CNT_W-1:0] lo_thresh,
   input  logic [CNT_W-1:0] hi_thresh,
   output logic             data_avail,
   output logic             pause_req
);

   pause_state_e state_q, state_d;

   assign data_avail = (count > lo_thresh);

   always_comb begin
      state_d = state_q;
      if (count_nxt > hi_thresh) begin
         state_d = PAUSE_ON;
      end else if (count_nxt <= lo_thresh) begin
         state_d = PAUSE_OFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PAUSE_OFF;
      else        state_q <= state_d;
   end

   assign pause_req = (state_q == PAUSE_ON);

   assert_pause_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pause_req) |-> (count > $past(hi_thresh)));
   assert_pause_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pause_req) |-> (count <= $past(lo_thresh)));

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
   import pkt_rx_fifo_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = ADDR_W + 1,
   localparam int WORD_W = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_lo_thresh,
   input  logic [CNT_W-1:0]  cfg_hi_thresh,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_sop,
   input  logic              wr_eop,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sop,
   output logic              rd_eop,
   output logic              data_avail,
   output logic              pkt_avail,
   output logic              pause_req,
   output logic              overflow
);

   if (DATA_W < 1) begin : g_bad_data
      $error("pkt_rx_fifo: DATA_W must be at least 1");
   end

   logic              wr_acc, rd_acc, head_eop, full;
   logic [WORD_W-1:0] rd_word;
   logic [CNT_W-1:0]  count, count_nxt;

   pkt_rx_fifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_word   ({wr_sop, wr_eop, wr_data}),
      .rd_en     (rd_en),
      .wr_acc    (wr_acc),
      .rd_acc    (rd_acc),
      .head_eop  (head_eop),
      .full      (full),
      .rd_word   (rd_word),
      .rd_valid  (rd_valid),
      .count     (count),
      .count_nxt (count_nxt)
   );

   assign rd_sop  = rd_word[WORD_W-1];
   assign rd_eop  = rd_word[WORD_W-2];
   assign rd_data = rd_word[DATA_W-1:0];

   pkt_rx_fifo_eopcnt #(.CNT_W(CNT_W)) u_eopcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (wr_acc & wr_eop),
      .dec       (rd_acc & head_eop),
      .pkt_avail (pkt_avail)
   );

   pkt_rx_fifo_flags #(.CNT_W(CNT_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .count      (count),
      .count_nxt  (count_nxt),
      .lo_thresh  (cfg_lo_thresh),
      .hi_thresh  (cfg_hi_thresh),
      .data_avail (data_avail),
      .pause_req  (pause_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                overflow <= 1'b0;
      else if (wr_valid && full) overflow <= 1'b1;
   end

   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   assert_pkt_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_avail |-> (count != '0));

endmodule

// File: tb/pkt_rx_fifo_tb.sv
`timescale 1ns/1ps
module pkt_rx_fifo_tb;

   localparam int DATA_W = 32;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = $clog2(DEPTH) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CNT_W-1:0] lo = 3, hi = 11;
   logic wv = 0, ws = 0, we = 0, re = 0;
   logic [DATA_W-1:0] wd = 0;
   logic rd_valid, rd_sop, rd_eop, data_avail, pkt_avail, pause_req, overflow;
   logic [DATA_W-1:0] rd_data;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pkt_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_lo_thresh(lo), .cfg_hi_thresh(hi),
      .wr_valid(wv), .wr_data(wd), .wr_sop(ws), .wr_eop(we), .rd_en(re),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
      .data_avail(data_avail), .pkt_avail(pkt_avail), .pause_req(pause_req),
      .overflow(overflow)
   );

   // behavioural reference: queue of {sop, eop, data}
   logic [DATA_W+1:0] q[$];
   logic m_rv = 0, m_pause = 0, m_ovf = 0;
   logic [DATA_W+1:0] m_rw = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_rv = 0; m_pause = 0; m_ovf = 0; m_rw = '0;
      end else begin
         int n;
         bit wacc, racc;
         n = q.size();
         wacc = wv && (n < DEPTH);
         racc = re && (n > 0);
         if (wv && n == DEPTH) m_ovf = 1;
         m_rv = racc;
         if (racc) m_rw = q.pop_front();
         if (wacc) q.push_back({ws, we, wd});
         n = q.size();
         if (n > int'(hi)) m_pause = 1;
         else if (n <= int'(lo)) m_pause = 0;
      end
   end

   function automatic bit m_pkt();
      foreach (q[i]) if (q[i][DATA_W]) return 1;
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(rd_valid == m_rv, "R2", "rd_valid", rd_valid, m_rv);
      if (m_rv) begin
         check({rd_sop, rd_eop, rd_data} == m_rw, "R1", "read word",
               {rd_sop, rd_eop, rd_data}, m_rw);
      end
      check(data_avail == (q.size() > int'(lo)), "R6", "data_avail",
            data_avail, q.size() > int'(lo));
      check(pkt_avail == m_pkt(), "R7", "pkt_avail", pkt_avail, m_pkt());
      check(pause_req == m_pause, "R8", "pause_req", pause_req, m_pause);
      check(overflow == m_ovf, "R4", "overflow", overflow, m_ovf);
   endtask

   // drive after a falling edge, let one rising edge pass, compare at the next falling edge
   task automatic step(input bit w, input logic [DATA_W-1:0] d, input bit s,
                       input bit e, input bit r);
      wv = w; wd = d; ws = s; we = e; re = r;
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset();
      rst_n = 0; wv = 0; re = 0; ws = 0; we = 0; wd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      // R10 reset state
      check({rd_valid, rd_data, rd_sop, rd_eop, data_avail, pkt_avail, pause_req, overflow} == '0,
            "R10", "outputs after reset",
            {rd_valid, rd_sop, rd_eop, data_avail, pkt_avail, pause_req, overflow}, 0);
      @(negedge clk);

      // R3 read on empty, then the next written word is the next word read
      repeat (3) step(0, 0, 0, 0, 1);
      check(rd_valid == 0, "R3", "rd_valid on empty", rd_valid, 0);
      step(1, 32'hA5A5_0001, 1, 1, 0);
      step(0, 0, 0, 0, 1);
      check(rd_valid && rd_data == 32'hA5A5_0001, "R3", "word after empty reads",
            rd_data, 32'hA5A5_0001);
      step(0, 0, 0, 0, 0);

      // fill beyond DEPTH: pause and overflow (R4, R8)
      for (int i = 0; i < 20; i++) step(1, 32'h100 + i, (i % 4) == 0, (i % 4) == 3, 0);
      check(overflow == 1, "R4", "overflow after writes into full", overflow, 1);
      check(pause_req == 1, "R8", "pause at full", pause_req, 1);
      // simultaneous read and write while full: write dropped
      step(1, 32'hDEAD_BEEF, 0, 0, 1);
      check(rd_valid && rd_data == 32'h100, "R4", "read while full", rd_data, 32'h100);
      // drain
      for (int i = 0; i < 18; i++) step(0, 0, 0, 0, 1);
      check(pause_req == 0, "R9", "pause released after drain", pause_req, 0);
      check(data_avail == 0, "R6", "data_avail empty", data_avail, 0);

      // R5: hold level with simultaneous read+write
      for (int i = 0; i < 6; i++) step(1, 32'h200 + i, 0, 0, 0);
      for (int i = 0; i < 5; i++) step(1, 32'h300 + i, 0, 0, 1);
      lo = 5; #1;
      check(data_avail == 1, "R5", "level 6 above mark 5", data_avail, 1);
      lo = 6; #1;
      check(data_avail == 0, "R5", "level 6 not above mark 6", data_avail, 0);
      lo = 3;
      @(negedge clk);
      for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1);

      // R9 hysteresis between marks
      for (int i = 0; i < 13; i++) step(1, 32'h400 + i, 0, 0, 0);
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1);
      check(pause_req == 1, "R9", "pause held between marks", pause_req, 1);
      for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1);

      // R7: end-of-packet written and read in the same cycle
      step(1, 32'h501, 1, 1, 0);
      step(1, 32'h502, 1, 1, 1);
      check(pkt_avail == 1, "R7", "pkt_avail across eop swap", pkt_avail, 1);
      step(0, 0, 0, 0, 1);
      check(pkt_avail == 0, "R7", "pkt_avail after last eop read", pkt_avail, 0);
      step(0, 0, 0, 0, 0);

      // random mixed traffic
      for (int i = 0; i < 4000; i++) begin
         if (i % 250 == 0) begin
            lo = CNT_W'($urandom_range(0, 7));
            hi = CNT_W'($urandom_range(8, 15));
         end
         step($urandom_range(0, 99) < 55, $urandom, $urandom_range(0, 3) == 0,
              $urandom_range(0, 3) == 0, $urandom_range(0, 99) < 50);
      end

      // R4/R10 overflow cleared only by reset
      for (int i = 0; i < 20; i++) step(1, i, 0, 0, 0);
      check(overflow == 1, "R4", "overflow set before reset", overflow, 1);
      do_reset();
      #1;
      check(overflow == 0 && pkt_avail == 0 && pause_req == 0, "R10", "flags cleared by reset",
            {overflow, pkt_avail, pause_req}, 0);
      @(negedge clk);
      step(0, 0, 0, 0, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule